// File: doc/BRIEF.md
# Masked BSSID Receive Filter

This block decides, for each received frame, whether its 48-bit network identifier belongs to one of the networks this station serves. A frame then counts as addressed to the station and should be acknowledged. The frame's identifier is not compared in full. Only the bit positions selected by a software-programmed mask take part, and on those positions it must agree with the station's own 48-bit hardware address. One station address can then cover several virtual networks at once. The cost is that some foreign identifiers agree on every selected bit and are accepted as well. That outcome is intended.

Software loads the station address and the mask through a small word-wide register port. Each value is split into a low 32-bit word and an upper 16-bit part. The upper address register also carries 16 unrelated control bits. The block stores these bits and returns them on read, so that software can update the address half with a read-modify-write. The frame side presents an identifier with a one-cycle valid strobe. One clock later the block returns a decision with its own valid strobe.

Top module: `bssid_mask_filter`

## Requirements
- R1: A frame is accepted when `(frm_bssid & mask) == (mac & mask)` over all 48 bits, and rejected otherwise.
- R2: `acc_valid` is high in exactly the cycle after each cycle with `frm_valid` high, and at no other time. `acc_match` is low whenever `acc_valid` is low.
- R3: The register map is as follows.
  - Address 0 holds address bits 31:0.
  - Address 1 holds address bits 47:32 in its bits 15:0, and opaque control bits in its bits 31:16.
  - Address 2 holds mask bits 31:0.
  - Address 3 holds mask bits 47:32 in its bits 15:0. Its bits 31:16 always read as zero.
  - Frame identifier bit i lines up with address and mask bit i.
- R4: The control bits in address 1 bits 31:16 are kept through writes to every other register. They never change the accept decision.
- R5: With every mask bit set, only an identifier equal to the station address in all 48 bits is accepted.
- R6: With every mask bit clear, every frame is accepted.
- R7: A frame that agrees with the address only on the masked bits is accepted, even if it belongs to no served network. Example: address 0x1 and mask 0x2 accept 0x1, 0x4, 0x9 and 0xD, and reject 0x6.
- R8: A register write in the same cycle as `frm_valid` does not affect that frame. It applies from the next frame onward.
- R9: After reset all four registers read zero and both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Write register select |
| reg_wdata | input | 32 | Write data |
| reg_rd_addr | input | 2 | Read register select |
| reg_rdata | output | 32 | Read data, combinational |
| frm_valid | input | 1 | Frame identifier valid |
| frm_bssid | input | 48 | Frame identifier |
| acc_valid | output | 1 | Decision valid, one clock after `frm_valid` |
| acc_match | output | 1 | Frame accepted |

## Verification
The hardest case to reach from the ports is a register write that lands in the same cycle as a frame. It needs both interfaces driven on one edge, and the expected decision must come from the configuration that was in force before the write. The driver has a combined task for this. It pushes the expected result from its shadow registers and only then updates the shadow copy. The next frame, which uses the old address, must then be rejected. The control bits are also written first and read back after every later write, to show they survive.

// File: rtl/bssid_mask_filter.sv
module bssid_mask_filter #(
  parameter int ID_W   = 48,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [1:0]        reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  input  logic [1:0]        reg_rd_addr,
  output logic [WORD_W-1:0] reg_rdata,
  input  logic              frm_valid,
  input  logic [ID_W-1:0]   frm_bssid,
  output logic              acc_valid,
  output logic              acc_match
);
  localparam int HI_W = ID_W - WORD_W;

  logic [WORD_W-1:0] addr_lo, addr_hi, msk_lo;
  logic [HI_W-1:0]   msk_hi;
  logic [ID_W-1:0]   own_id, sel;
  logic              hit;

  assign own_id = {addr_hi[HI_W-1:0], addr_lo};
  assign sel    = {msk_hi, msk_lo};
  assign hit    = ((frm_bssid ^ own_id) & sel) == '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_lo <= '0;
      addr_hi <= '0;
      msk_lo  <= '0;
      msk_hi  <= '0;
    end else if (reg_wr_en) begin
      case (reg_addr)
        2'd0: addr_lo <= reg_wdata;
        2'd1: addr_hi <= reg_wdata;
        2'd2: msk_lo  <= reg_wdata;
        default: msk_hi <= reg_wdata[HI_W-1:0];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_valid <= 1'b0;
      acc_match <= 1'b0;
    end else begin
      acc_valid <= frm_valid;
      acc_match <= frm_valid & hit;
    end
  end

  always_comb begin
    case (reg_rd_addr)
      2'd0: reg_rdata = addr_lo;
      2'd1: reg_rdata = addr_hi;
      2'd2: reg_rdata = msk_lo;
      default: reg_rdata = {{(WORD_W-HI_W){1'b0}}, msk_hi};
    endcase
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) frm_valid |=> acc_valid); // R2
  AST_NO_STRAY_VALID: assert property (@(posedge clk) disable iff (!rst_n) !frm_valid |=> !acc_valid); // R2
  AST_MATCH_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !acc_valid |-> !acc_match); // R2
  AST_OPEN_MASK: assert property (@(posedge clk) disable iff (!rst_n) (frm_valid && sel == '0) |=> acc_match); // R6
  AST_FULL_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && sel == '1 && frm_bssid != own_id) |=> !acc_match); // R5
  AST_CTRL_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && reg_addr != 2'd1) |=> $stable(addr_hi)); // R4
endmodule

// File: tb/tb_bssid_mask_filter.sv
module tb_bssid_mask_filter;
  logic        clk = 0, rst_n = 0;
  logic        reg_wr_en = 0;
  logic [1:0]  reg_addr = 0, reg_rd_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic        frm_valid = 0;
  logic [47:0] frm_bssid = 0;
  logic        acc_valid, acc_match;

  bssid_mask_filter dut (.*);

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0;
  bit    exp_q[$];
  string tag_q[$];
  logic [31:0] sh_lo = 0, sh_hi = 0, sm_lo = 0, sm_hi = 0;
  bit done = 0;

  function automatic bit model(logic [47:0] b);
    logic [47:0] m, k;
    m = {sh_hi[15:0], sh_lo};
    k = {sm_hi[15:0], sm_lo};
    return (b & k) == (m & k);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic shadow(logic [1:0] a, logic [31:0] d);
    case (a)
      2'd0: sh_lo = d;
      2'd1: sh_hi = d;
      2'd2: sm_lo = d;
      default: sm_hi = {16'h0, d[15:0]};
    endcase
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1; reg_addr = a; reg_wdata = d;
    shadow(a, d);
    @(negedge clk);
    reg_wr_en = 0;
  endtask

  task automatic rd(string req, logic [1:0] a, logic [31:0] exp);
    reg_rd_addr = a;
    #1;
    chk(req, reg_rdata, exp);
  endtask

  task automatic send(string req, logic [47:0] b);
    @(negedge clk);
    frm_valid = 1; frm_bssid = b;
    exp_q.push_back(model(b)); tag_q.push_back(req);
    @(negedge clk);
    frm_valid = 0;
  endtask

  task automatic send_wr(string req, logic [47:0] b, logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    frm_valid = 1; frm_bssid = b;
    reg_wr_en = 1; reg_addr = a; reg_wdata = d;
    exp_q.push_back(model(b)); tag_q.push_back(req);
    shadow(a, d);
    @(negedge clk);
    frm_valid = 0; reg_wr_en = 0;
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (acc_valid) begin
        if (exp_q.size() == 0) begin
          checks++; fails++;
          $display("FAIL R2 actual=unexpected acc_valid expected=none");
        end else begin
          bit e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(t, {31'h0, acc_match}, {31'h0, e});
        end
      end else begin
        if (acc_match) chk("R2", {31'h0, acc_match}, 32'h0);
      end
    end
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R9", {30'h0, acc_valid, acc_match}, 32'h0);
    for (int i = 0; i < 4; i++) rd("R9", i[1:0], 32'h0);

    send("R6", 48'hFEDC_BA98_7654);
    send("R6", 48'h0);

    wr(2'd0, 32'h0000_0001);
    wr(2'd1, 32'h0000_0000);
    wr(2'd2, 32'h0000_0002);
    wr(2'd3, 32'h0000_0000);
    send("R7", 48'h1);
    send("R7", 48'h4);
    send("R7", 48'h9);
    send("R7", 48'hD);
    send("R7", 48'h6);

    wr(2'd2, 32'h0F0F_00FF);
    wr(2'd3, 32'h0000_8001);
    wr(2'd0, 32'h1357_9BDF);
    send("R1", 48'h0000_1357_9BDF);
    send("R1", 48'h8000_0000_00DF);
    send("R1", 48'h0001_1357_9BDF);
    send("R1", 48'h7FFE_F0F0_9B00);

    wr(2'd1, 32'hA5A5_1234);
    wr(2'd0, 32'h5678_9ABC);
    wr(2'd2, 32'hFFFF_FFFF);
    wr(2'd3, 32'hFFFF_FFFF);
    rd("R3", 2'd0, 32'h5678_9ABC);
    rd("R4", 2'd1, 32'hA5A5_1234);
    rd("R3", 2'd2, 32'hFFFF_FFFF);
    rd("R3", 2'd3, 32'h0000_FFFF);
    send("R4", 48'h1234_5678_9ABC);
    send("R5", 48'h9234_5678_9ABC);
    send("R5", 48'h1234_5678_9ABD);

    send_wr("R8", 48'h1234_5678_9ABC, 2'd0, 32'h0000_0000);
    send("R8", 48'h1234_5678_9ABC);
    send("R8", 48'h1234_0000_0000);
    rd("R4", 2'd1, 32'hA5A5_1234);

    repeat (4) @(negedge clk);
    if (exp_q.size() != 0) begin
      checks++; fails++;
      $display("FAIL R2 actual=%0d pending expected=0", exp_q.size());
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule